// File: doc/BRIEF.md
# I2C Target Engine with Per-Byte Clock Stretching

This block is the target (slave) side of an I2C bus. It runs from a fast system clock and oversamples the bus clock and data lines. It recognises START, repeated START and STOP. It takes in a 7-bit address and a direction bit, and acknowledges when the address equals the programmed own address. Data bytes then move in the requested direction.

After every byte that completes with an acknowledge, the block raises a byte-complete interrupt flag. It then holds the bus clock low until host logic clears the flag. Because of this stall, a host with slow service timing can never lose a byte: the master simply waits.

Both bus lines are open-drain. The block never drives a line high. It only asserts an output enable that pulls the line low, and the pad and pull-up stay outside the block.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: Both lines pass through a two-stage synchroniser. A falling SDA while SCL is high is a START and moves the engine to address reception. A rising SDA while SCL is high is a STOP and returns the engine to idle with both output enables low.
- R2: The first byte after a START is sampled on SCL rising edges, most significant bit first. Its upper seven bits are the address and bit 0 is the direction (0 = master writes, 1 = master reads). When the address equals `own_addr` and `ack_en` is high, `sda_oe` is high from the eighth SCL fall through the ninth SCL fall.
- R3: When the address differs, or `ack_en` is low at the address byte, the engine never asserts `sda_oe` or `scl_oe` until the next START.
- R4: After each acknowledged byte (address, received data, or transmitted data that the master acknowledged), `irq` rises at the ninth SCL fall and `scl_oe` is asserted together with it. `scl_oe` stays asserted while `irq` stays set. For an address byte, `rx_byte` holds the full address byte including the direction bit, and `rd_mode` holds the direction bit.
- R5: When `irq_clr` is sampled high while `irq` is set, `irq` and `scl_oe` are both low after that same clock edge, one clock after the write.
- R6: In the write direction, each data byte is shifted in MSB first and acknowledged when `ack_en` is high, and `rx_byte` then shows the byte. When `ack_en` is low, SDA stays released in the ninth slot, the byte is discarded, and no interrupt is raised.
- R7: In the read direction, clearing `irq` loads `tx_byte` and puts its MSB on SDA at once. The following bits change after SCL falls, and SDA is released for the master's acknowledge slot.
- R8: A master NACK after a transmitted byte ends the transmission. SDA stays released, no interrupt is raised, and the engine waits for STOP or START.
- R9: A START or STOP in the middle of a byte aborts the transfer. The bit count restarts, the interrupt flag and any stretch are cleared, and a repeated START begins a new address phase.
- R10: `sda_oe` changes only while the synchronised SCL is low, except when a START or STOP clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge or data 0) |
| own_addr | input | 7 | Address this target answers to |
| ack_en | input | 1 | Allow acknowledges of address and received data |
| tx_byte | input | 8 | Byte to transmit, loaded when the flag is cleared |
| rx_byte | output | 8 | Last received byte (address byte included) |
| rd_mode | output | 1 | Direction bit of the current transfer |
| irq | output | 1 | Byte-complete interrupt flag |
| irq_clr | input | 1 | Clear the flag and release the stretch |

## Verification
The bench builds the block with its default parameters: 8-bit data, a two-stage synchroniser, and an own address of 0x3A. The master model in the bench uses a quarter bit period of eight system clocks. That spacing lets the synchroniser delay show while still letting the model see a stretched SCL and wait for it. With these settings the bench can reach all of the following: address matches and mismatches, both directions, NACKs from either side, repeated START, aborts mid-byte, and the exact clock on which a stretch is released.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types of the I2C target engine.
// Assumes: only one engine state machine uses this enum.
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // bus not addressed to us
        ST_ADDR,   // shifting address + direction bit
        ST_AACK,   // driving address acknowledge
        ST_RX,     // receiving a data byte
        ST_RACK,   // driving data acknowledge
        ST_TX,     // transmitting a data byte
        ST_TACK,   // reading master acknowledge
        ST_WAIT    // finished, waiting for START or STOP
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: i2c_tgt_sync
// Brings SCL and SDA into the clock domain through a flip-flop chain and
// derives SCL edges plus START/STOP events from the synchronised levels.
// Assumes: clk is several times faster than SCL; idle bus level is high.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
            for (int i = 1; i < STAGES; i++) begin
                scl_ff[i] <= scl_ff[i-1];
                sda_ff[i] <= sda_ff[i-1];
            end
            scl_d <= scl_ff[STAGES-1];
            sda_d <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Module: i2c_tgt_fsm
// Byte engine: address compare, receive/transmit shifting, acknowledge
// generation, byte-complete flag and SCL stretch until the flag is cleared.
// Assumes: inputs come from i2c_tgt_sync; DATA_W = address width + 1.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              irq_clr,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rd_mode,
    output logic              irq
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    tgt_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sr;
    logic              mack;

    // Main engine: bus events first, then host clear, then per-state work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sr      <= '0;
            mack    <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            rx_byte <= '0;
            rd_mode <= 1'b0;
            irq     <= 1'b0;
        end else if (start_det || stop_det) begin
            state  <= start_det ? ST_ADDR : ST_IDLE;
            cnt    <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (irq && irq_clr) begin
                irq    <= 1'b0;
                scl_oe <= 1'b0;
                if (state == ST_TX && cnt == '0) begin
                    sr     <= tx_byte;
                    sda_oe <= ~tx_byte[DATA_W-1];
                end
            end
            case (state)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        sr  <= {sr[DATA_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        if (state == ST_ADDR) begin
                            if (sr[DATA_W-1:1] == own_addr && ack_en) begin
                                sda_oe  <= 1'b1;
                                rd_mode <= sr[0];
                                state   <= ST_AACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (ack_en) begin
                            sda_oe <= 1'b1;
                            state  <= ST_RACK;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_AACK, ST_RACK: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        rx_byte <= sr;
                        irq     <= 1'b1;
                        scl_oe  <= 1'b1;
                        cnt     <= '0;
                        state   <= (state == ST_AACK && rd_mode) ? ST_TX : ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TACK;
                    end else if (scl_fall && cnt != '0) begin
                        sda_oe <= ~sr[DATA_W-2];
                        sr     <= sr << 1;
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            irq    <= 1'b1;
                            scl_oe <= 1'b1;
                            cnt    <= '0;
                            state  <= ST_TX;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Assertions guarding the engine.
    p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && cnt == '0));
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK) |-> sda_oe);
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_oe && !scl_oe));
    p_irq_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> scl_oe);
    p_stretch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr && !start_det && !stop_det) |=> scl_oe);
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_clr) |=> (!scl_oe && !irq));
    p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (!sda_oe && !irq));
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> (!scl_oe && !sda_oe && !irq));
    p_sda_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(!scl_s) || $past(start_det) || $past(stop_det)));
endmodule

// File: rtl/i2c_tgt_stretch.sv
// Module: i2c_tgt_stretch (top)
// I2C target with a byte-complete flag and SCL stretch after every
// acknowledged byte. Open-drain lines are modelled as pull-low enables.
// Assumes: external pull-ups; pads combine the enables with the line.
module i2c_tgt_stretch #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rd_mode,
    output logic              irq,
    input  logic              irq_clr
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_addr  (own_addr),
        .ack_en    (ack_en),
        .tx_byte   (tx_byte),
        .irq_clr   (irq_clr),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rx_byte   (rx_byte),
        .rd_mode   (rd_mode),
        .irq       (irq)
    );
endmodule

// File: tb/i2c_tgt_stretch_tb.sv
// Bench: bus master model plus host model, random and directed transfers.
module i2c_tgt_stretch_tb;
    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst_n;
    logic m_scl_low, m_sda_low;
    logic scl_oe, sda_oe, rd_mode, irq, irq_clr, ack_en;
    logic [7:0] tx_byte, rx_byte;
    logic [6:0] own_addr;
    logic mon_en;
    int   drive_cnt;
    int   nchk = 0;
    int   nerr = 0;

    wire scl_line = !(m_scl_low || scl_oe);
    wire sda_line = !(m_sda_low || sda_oe);

    always #4 clk = ~clk;

    i2c_tgt_stretch u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .ack_en(ack_en),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rd_mode(rd_mode), .irq(irq),
        .irq_clr(irq_clr)
    );

    // Counts any drive by the target while monitoring a foreign transfer.
    always @(posedge clk) if (mon_en && (sda_oe || scl_oe)) drive_cnt++;

    function automatic logic exp_addr_ack(input logic [6:0] a, input logic en);
        return (a == OWN) && en;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_rel();
        m_scl_low = 1'b0;
        wait_clk(1);
        while (!scl_line) wait_clk(1);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; wait_clk(Q);
        scl_rel();        wait_clk(Q);
        m_sda_low = 1'b1; wait_clk(Q);
        m_scl_low = 1'b1; wait_clk(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wait_clk(Q);
        scl_rel();        wait_clk(Q);
        m_sda_low = 1'b0; wait_clk(Q);
    endtask

    task automatic m_bit_write(input logic b);
        m_sda_low = !b; wait_clk(Q);
        scl_rel();      wait_clk(Q);
        m_scl_low = 1'b1; wait_clk(Q);
    endtask

    task automatic m_bit_read(output logic b);
        m_sda_low = 1'b0; wait_clk(Q);
        scl_rel();        wait_clk(Q);
        b = sda_line;
        m_scl_low = 1'b1; wait_clk(Q);
    endtask

    task automatic m_write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_write(d[i]);
        m_bit_read(b);
        ack = !b;
    endtask

    task automatic m_read_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_read(b);
            d[i] = b;
        end
        m_bit_write(!ack);
    endtask

    task automatic service(input logic [7:0] nxt);
        tx_byte = nxt;
        irq_clr = 1'b1;
        wait_clk(1);
        irq_clr = 1'b0;
    endtask

    // One transfer: address, n data bytes in direction rd, optional STOP.
    task automatic txn(input logic [6:0] a, input logic rd, input int n, input logic do_stop);
        logic ack, exp;
        logic [7:0] d, got;
        exp = exp_addr_ack(a, ack_en);
        if (!exp) begin mon_en = 1'b1; drive_cnt = 0; end
        m_start();
        m_write_byte({a, rd}, ack);
        chk("R2 address ack", ack, exp);
        wait_clk(4);
        if (!exp) begin
            chk("R3 no irq", irq, 1'b0);
            m_write_byte($urandom, ack);
            chk("R3 data ignored", ack, 1'b0);
        end else begin
            chk("R4 irq after address", irq, 1'b1);
            chk("R4 rx_byte address", rx_byte, {a, rd});
            chk("R4 rd_mode", rd_mode, rd);
            d = $urandom;
            service(d);
            for (int i = 0; i < n; i++) begin
                if (rd) begin
                    m_read_byte(got, i < n - 1);
                    chk("R7 read data", got, d);
                    wait_clk(4);
                    if (i < n - 1) begin
                        chk("R4 irq after tx byte", irq, 1'b1);
                        d = $urandom;
                        service(d);
                    end else begin
                        chk("R8 no irq after nack", irq, 1'b0);
                        chk("R8 sda released", sda_oe, 1'b0);
                    end
                end else begin
                    d = $urandom;
                    m_write_byte(d, ack);
                    chk("R6 data ack", ack, 1'b1);
                    wait_clk(4);
                    chk("R4 irq after rx byte", irq, 1'b1);
                    chk("R6 rx_byte", rx_byte, d);
                    service(8'h00);
                end
            end
        end
        if (do_stop) begin
            m_stop();
            wait_clk(4);
            chk("R1 idle after stop", {scl_oe, sda_oe}, 2'b00);
        end
        if (!exp) begin
            chk("R3 never drove", drive_cnt, 0);
            mon_en = 1'b0;
        end
    endtask

    initial begin
        logic ack;
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
        irq_clr = 1'b0; ack_en = 1'b1; tx_byte = '0; own_addr = OWN;
        mon_en = 1'b0; drive_cnt = 0;
        wait_clk(5);
        chk("R4 reset irq", irq, 1'b0);
        chk("R1 reset outputs", {scl_oe, sda_oe}, 2'b00);
        rst_n = 1'b1;
        wait_clk(5);

        // Directed: both directions, mismatch, repeated START.
        txn(OWN, 1'b0, 2, 1'b1);
        txn(OWN, 1'b1, 3, 1'b1);
        txn(OWN ^ 7'h01, 1'b0, 1, 1'b1);
        txn(OWN, 1'b0, 1, 1'b0);
        txn(OWN, 1'b1, 1, 1'b1);   // R9 repeated START into read

        // R3: ack_en low at address.
        ack_en = 1'b0;
        txn(OWN, 1'b0, 1, 1'b1);
        ack_en = 1'b1;

        // R6: ack_en low on a data byte.
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        wait_clk(4);
        service(8'h00);
        ack_en = 1'b0;
        m_write_byte(8'hA5, ack);
        chk("R6 nack when disabled", ack, 1'b0);
        wait_clk(4);
        chk("R6 no irq when disabled", irq, 1'b0);
        ack_en = 1'b1;
        m_stop();

        // R9: STOP after three bits of a data byte.
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        wait_clk(4);
        service(8'h00);
        m_bit_write(1'b1); m_bit_write(1'b0); m_bit_write(1'b1);
        m_stop();
        wait_clk(4);
        chk("R9 abort outputs", {scl_oe, sda_oe, irq}, 3'b000);
        txn(OWN, 1'b0, 1, 1'b1);

        // R4/R5: master tries to raise SCL while flag is set.
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        wait_clk(4);
        service(8'h00);
        m_write_byte(8'h3C, ack);
        wait_clk(4);
        m_sda_low = 1'b1; wait_clk(Q);
        m_scl_low = 1'b0; wait_clk(20);
        chk("R4 scl held low", scl_line, 1'b0);
        chk("R5 stretch before clear", scl_oe, 1'b1);
        irq_clr = 1'b1;
        wait_clk(1);
        irq_clr = 1'b0;
        chk("R5 released one clock after clear", scl_oe, 1'b0);
        chk("R5 flag cleared", irq, 1'b0);
        while (!scl_line) wait_clk(1);
        wait_clk(Q);
        m_sda_low = 1'b0; wait_clk(Q);
        chk("R1 idle after stop", {scl_oe, sda_oe}, 2'b00);

        // Random transfers.
        for (int k = 0; k < 12; k++) begin
            logic [6:0] a;
            a = ($urandom % 4 == 0) ? (OWN ^ 7'(1 + $urandom % 127)) : OWN;
            txn(a, 1'($urandom), 1 + int'($urandom % 3), 1'($urandom % 3 != 0));
        end
        m_stop();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule